// File: doc/BRIEF.md
# Multi-Channel DAC Command Decoder

This block is the digital front end on the device side of a multi-channel digital-to-analog converter. A host sends 24-bit command frames over an SPI slave link: a serial clock, a data line and an active-low select. The block brings these three lines into the system clock domain, assembles the frame and decodes it. It then updates a two-stage register set for each channel. The first stage is a holding register that the host loads. The second stage is the active register that drives the converter.

The block also keeps a powerdown bit per channel, a whole-device powerdown flag and a reference-source select. The active codes of all channels, the powerdown state and the reference select leave the block as parallel outputs that feed the analog macro. The channel count (2, 4 or 8) and the code resolution (8, 10 or 12 bits) are set by parameters. The SPI serial clock must stay high and low for at least three system clock periods each, so that the synchroniser can see every edge.

Top module: `dac_cmd_core`

## Requirements
- R1: A frame is 24 bits long and is sent most significant bit first. Bits 23:20 hold the opcode, bits 19:16 hold the channel index and bits 15:0 hold the data field. The data line is sampled on each rising edge of the serial clock seen while select is low.
- R2: The code is left-justified in the data field and occupies the top CODE_W bits (15 down to 16-CODE_W). The data bits below the code have no effect on any output.
- R3: A frame is acted on only when select rises, and only if exactly 24 bits were clocked in since select fell. A frame with fewer or more bits changes no output.
- R4: Opcode 0x0 loads the code into the holding register of the indexed channel only. No output changes.
- R5: Opcode 0x1 copies the holding register of the indexed channel into its active register. It also clears that channel's powerdown bit and the whole-device powerdown flag.
- R6: Opcode 0x2 loads the code into the indexed channel's holding register. It then copies the holding register into the active register for every channel, which includes the new code. All channel powerdown bits and the device powerdown flag are cleared.
- R7: Opcode 0x3 loads the code into both registers of the indexed channel. It clears that channel's powerdown bit and the device powerdown flag, and leaves the other channels unchanged.
- R8: Opcode 0x4 sets the powerdown bit of the indexed channel. Opcode 0x5 sets the device powerdown flag, whatever the index.
- R9: Opcode 0x6 drives ext_ref_o to 0 (internal reference). Opcode 0x7 drives it to 1 (external reference). The index and data fields are ignored for both.
- R10: For opcodes 0x0 to 0x4, an index at or above NUM_CH changes no state. Opcodes 0x8 to 0xF change no state.
- R11: After reset, every holding and active register is zero, no channel or device powerdown is set and ext_ref_o is 0.
- R12: The outputs change only in the clock cycle that follows the acceptance of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sck_i | input | 1 | SPI serial clock, asynchronous to clk_i |
| mosi_i | input | 1 | SPI serial data from the host |
| cs_ni | input | 1 | SPI select, active low |
| dac_code_o | output | NUM_CH*CODE_W | Active codes; channel i is at bits [i*CODE_W +: CODE_W] |
| chan_pd_o | output | NUM_CH | Powerdown bit per channel, 1 = powered down |
| chip_pd_o | output | 1 | Whole-device powerdown flag |
| ext_ref_o | output | 1 | Reference select, 1 = external |

## Verification
The bound checker watches the accepted frame on every cycle. It confirms that the outputs stay still unless a frame was accepted, and that a frame with an out-of-range index or an unused opcode leaves them still. It also checks the effect of each powerdown and reference opcode, and that the update opcodes clear the powerdown state. The other behaviour can only be shown by the bench's scenarios against its reference model. This covers the serial bit count and bit order, the extraction of the left-justified code, and the difference between loading the holding register and loading the active register. It also covers the update-all opcode taking in the newly written code, and frames that are too short or too long being dropped.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int FRAME_W = 24;
  localparam int DATA_W  = 16;

  typedef enum logic [3:0] {
    OP_WR_HOLD     = 4'h0,
    OP_LOAD        = 4'h1,
    OP_WR_LOAD_ALL = 4'h2,
    OP_WR_LOAD     = 4'h3,
    OP_PD_CHAN     = 4'h4,
    OP_PD_CHIP     = 4'h5,
    OP_REF_INT     = 4'h6,
    OP_REF_EXT     = 4'h7
  } dac_op_e;

  function automatic logic [3:0] frame_op(input logic [FRAME_W-1:0] f);
    return f[23:20];
  endfunction

  function automatic logic [3:0] frame_idx(input logic [FRAME_W-1:0] f);
    return f[19:16];
  endfunction
endpackage

// File: rtl/dac_spi_rx.sv
module dac_spi_rx #(
  parameter int FRAME_W     = 24,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               sck_i,
  input  logic               mosi_i,
  input  logic               cs_ni,
  output logic               frame_vld_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(FRAME_W);
  localparam logic [CNT_W-1:0] CNT_SAT  = CNT_W'(FRAME_W + 1);

  logic [SYNC_STAGES-1:0] sck_sync, mosi_sync, cs_sync;
  logic sck_d, cs_d;
  logic [CNT_W-1:0] bit_cnt;
  logic [FRAME_W-1:0] shift_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_sync  <= '0;
      mosi_sync <= '0;
      cs_sync   <= '1;
    end else begin
      sck_sync  <= {sck_sync[SYNC_STAGES-2:0], sck_i};
      mosi_sync <= {mosi_sync[SYNC_STAGES-2:0], mosi_i};
      cs_sync   <= {cs_sync[SYNC_STAGES-2:0], cs_ni};
    end
  end

  logic sck_s, mosi_s, cs_s, bit_stb, cs_rise;
  assign sck_s   = sck_sync[SYNC_STAGES-1];
  assign mosi_s  = mosi_sync[SYNC_STAGES-1];
  assign cs_s    = cs_sync[SYNC_STAGES-1];
  assign bit_stb = sck_s & ~sck_d & ~cs_s;
  assign cs_rise = cs_s & ~cs_d;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sck_d       <= 1'b0;
      cs_d        <= 1'b1;
      bit_cnt     <= '0;
      shift_q     <= '0;
      frame_vld_o <= 1'b0;
      frame_o     <= '0;
    end else begin
      sck_d       <= sck_s;
      cs_d        <= cs_s;
      frame_vld_o <= 1'b0;
      if (cs_rise) begin
        frame_vld_o <= (bit_cnt == CNT_FULL);
        frame_o     <= shift_q;
        bit_cnt     <= '0;
      end else if (bit_stb) begin
        shift_q <= {shift_q[FRAME_W-2:0], mosi_s};
        if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dac_cmd_decode.sv
module dac_cmd_decode
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               frame_vld_i,
  input  logic [FRAME_W-1:0] frame_i,
  output logic [NUM_CH-1:0]  wr_hold_o,
  output logic [NUM_CH-1:0]  load_o,
  output logic [NUM_CH-1:0]  pd_set_o,
  output logic [CODE_W-1:0]  code_o,
  output logic               chip_pd_o,
  output logic               ext_ref_o
);
  localparam logic [4:0] NCH = 5'(NUM_CH);

  dac_op_e    op;
  logic [3:0] idx;
  logic       idx_ok, any_load;

  assign op     = dac_op_e'(frame_op(frame_i));
  assign idx    = frame_idx(frame_i);
  assign idx_ok = frame_vld_i && ({1'b0, idx} < NCH);
  assign code_o = frame_i[DATA_W-1 -: CODE_W];
  assign any_load = idx_ok && (op inside {OP_LOAD, OP_WR_LOAD_ALL, OP_WR_LOAD});

  for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
    localparam logic [3:0] IDX = 4'(i);
    logic hit;
    assign hit          = idx_ok && (idx == IDX);
    assign wr_hold_o[i] = hit && (op inside {OP_WR_HOLD, OP_WR_LOAD_ALL, OP_WR_LOAD});
    assign load_o[i]    = (hit && (op inside {OP_LOAD, OP_WR_LOAD}))
                        || (idx_ok && op == OP_WR_LOAD_ALL);
    assign pd_set_o[i]  = hit && op == OP_PD_CHAN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      chip_pd_o <= 1'b0;
      ext_ref_o <= 1'b0;
    end else if (frame_vld_i) begin
      if (op == OP_PD_CHIP)    chip_pd_o <= 1'b1;
      else if (any_load)       chip_pd_o <= 1'b0;
      if (op == OP_REF_INT)    ext_ref_o <= 1'b0;
      else if (op == OP_REF_EXT) ext_ref_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_chan_reg.sv
module dac_chan_reg #(
  parameter int CODE_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_hold_i,
  input  logic              load_i,
  input  logic              pd_set_i,
  input  logic [CODE_W-1:0] code_i,
  output logic [CODE_W-1:0] dac_o,
  output logic              pd_o
);
  logic [CODE_W-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      dac_o  <= '0;
      pd_o   <= 1'b0;
    end else begin
      if (wr_hold_i) hold_q <= code_i;
      // write-and-load forwards the new code past the holding stage
      if (load_i) dac_o <= wr_hold_i ? code_i : hold_q;
      if (load_i) pd_o <= 1'b0;
      else if (pd_set_i) pd_o <= 1'b1;
    end
  end
endmodule

// File: rtl/dac_cmd_core.sv
module dac_cmd_core
  import dac_cmd_pkg::*;
#(
  parameter int NUM_CH      = 8,
  parameter int CODE_W      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       sck_i,
  input  logic                       mosi_i,
  input  logic                       cs_ni,
  output logic [NUM_CH*CODE_W-1:0]   dac_code_o,
  output logic [NUM_CH-1:0]          chan_pd_o,
  output logic                       chip_pd_o,
  output logic                       ext_ref_o
);
  logic               frame_vld;
  logic [FRAME_W-1:0] frame_q;
  logic [NUM_CH-1:0]  wr_hold, load, pd_set;
  logic [CODE_W-1:0]  code;

  dac_spi_rx #(.FRAME_W(FRAME_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk_i, .rst_ni, .sck_i, .mosi_i, .cs_ni,
    .frame_vld_o(frame_vld), .frame_o(frame_q)
  );

  dac_cmd_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
    .clk_i, .rst_ni,
    .frame_vld_i(frame_vld), .frame_i(frame_q),
    .wr_hold_o(wr_hold), .load_o(load), .pd_set_o(pd_set), .code_o(code),
    .chip_pd_o, .ext_ref_o
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    dac_chan_reg #(.CODE_W(CODE_W)) u_ch (
      .clk_i, .rst_ni,
      .wr_hold_i(wr_hold[i]), .load_i(load[i]), .pd_set_i(pd_set[i]),
      .code_i(code),
      .dac_o(dac_code_o[i*CODE_W +: CODE_W]),
      .pd_o(chan_pd_o[i])
    );
  end
endmodule

// File: rtl/dac_cmd_core_chk.sv
module dac_cmd_core_chk #(
  parameter int NUM_CH = 8,
  parameter int CODE_W = 12
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     frame_vld,
  input logic [23:0]              frame_q,
  input logic [NUM_CH*CODE_W-1:0] dac_code_o,
  input logic [NUM_CH-1:0]        chan_pd_o,
  input logic                     chip_pd_o,
  input logic                     ext_ref_o
);
  logic [3:0] op;
  logic       idx_ok;
  logic [NUM_CH-1:0] sel_oh;
  logic [NUM_CH*CODE_W+NUM_CH+1:0] outs;

  assign op     = frame_q[23:20];
  assign idx_ok = {1'b0, frame_q[19:16]} < 5'(NUM_CH);
  assign sel_oh = idx_ok ? (NUM_CH'(1) << frame_q[19:16]) : '0;
  assign outs   = {dac_code_o, chan_pd_o, chip_pd_o, ext_ref_o};

  // R12
  quiet_when_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !frame_vld |=> $stable(outs));
  // R10
  bad_index_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && !idx_ok && op <= 4'h4) |=> $stable(outs));
  // R10
  unused_op_ignored_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op[3]) |=> $stable(outs));
  // R8
  chan_pd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op == 4'h4 && idx_ok) |=> ((chan_pd_o & $past(sel_oh)) == $past(sel_oh)));
  // R8
  chip_pd_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op == 4'h5) |=> chip_pd_o);
  // R9
  ref_int_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op == 4'h6) |=> !ext_ref_o);
  // R9
  ref_ext_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op == 4'h7) |=> ext_ref_o);
  // R6
  load_all_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && op == 4'h2 && idx_ok) |=> (chan_pd_o == '0 && !chip_pd_o));
  // R5 R7
  load_one_wake_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (frame_vld && (op == 4'h1 || op == 4'h3) && idx_ok)
      |=> ((chan_pd_o & $past(sel_oh)) == '0 && !chip_pd_o));
endmodule

bind dac_cmd_core dac_cmd_core_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .frame_vld(frame_vld), .frame_q(frame_q),
  .dac_code_o(dac_code_o), .chan_pd_o(chan_pd_o), .chip_pd_o(chip_pd_o),
  .ext_ref_o(ext_ref_o)
);

// File: tb/dac_cmd_core_test.sv
module dac_cmd_core_test;
  localparam int NCH = 4;
  localparam int CW  = 10;
  localparam int HP  = 4;

  logic clk = 1'b0;
  logic rst_n;
  logic sck = 1'b0, mosi = 1'b0, cs_n = 1'b1;
  logic [NCH*CW-1:0] dac_code;
  logic [NCH-1:0]    chan_pd;
  logic              chip_pd, ext_ref;

  always #10 clk = ~clk;

  dac_cmd_core #(.NUM_CH(NCH), .CODE_W(CW)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sck_i(sck), .mosi_i(mosi), .cs_ni(cs_n),
    .dac_code_o(dac_code), .chan_pd_o(chan_pd), .chip_pd_o(chip_pd), .ext_ref_o(ext_ref)
  );

  int vectors = 0, miscompares = 0;
  int exp_hold[NCH], exp_dac[NCH];
  bit exp_pd[NCH];
  bit exp_chip = 0, exp_ext = 0;
  bit cmp_en = 0;
  string cur_req = "R11";

  always @(negedge clk) begin
    if (cmp_en) begin
      vectors++;
      for (int i = 0; i < NCH; i++) begin
        if (int'(dac_code[i*CW +: CW]) != exp_dac[i]) begin
          miscompares++;
          $display("FAIL %s code ch%0d got %0h exp %0h", cur_req, i, dac_code[i*CW +: CW], exp_dac[i]);
        end
        if (chan_pd[i] != exp_pd[i]) begin
          miscompares++;
          $display("FAIL %s pd ch%0d got %0b exp %0b", cur_req, i, chan_pd[i], exp_pd[i]);
        end
      end
      if (chip_pd != exp_chip) begin
        miscompares++;
        $display("FAIL %s chip_pd got %0b exp %0b", cur_req, chip_pd, exp_chip);
      end
      if (ext_ref != exp_ext) begin
        miscompares++;
        $display("FAIL %s ext_ref got %0b exp %0b", cur_req, ext_ref, exp_ext);
      end
    end
  end

  task automatic model(input int op, input int idx, input int data);
    int code = (data >> (16 - CW)) & ((1 << CW) - 1);
    bit ok = idx < NCH;
    case (op)
      0: if (ok) exp_hold[idx] = code;
      1: if (ok) begin exp_dac[idx] = exp_hold[idx]; exp_pd[idx] = 0; exp_chip = 0; end
      2: if (ok) begin
           exp_hold[idx] = code;
           for (int i = 0; i < NCH; i++) begin exp_dac[i] = exp_hold[i]; exp_pd[i] = 0; end
           exp_chip = 0;
         end
      3: if (ok) begin exp_hold[idx] = code; exp_dac[idx] = code; exp_pd[idx] = 0; exp_chip = 0; end
      4: if (ok) exp_pd[idx] = 1;
      5: exp_chip = 1;
      6: exp_ext = 0;
      7: exp_ext = 1;
      default: ;
    endcase
  endtask

  task automatic shift_out(input logic [31:0] word, input int nbits);
    cmp_en = 0;
    cs_n = 1'b0;
    repeat (HP) @(posedge clk);
    for (int b = nbits - 1; b >= 0; b--) begin
      mosi = word[b];
      repeat (HP) @(posedge clk);
      sck = 1'b1;
      repeat (HP) @(posedge clk);
      sck = 1'b0;
    end
    repeat (HP) @(posedge clk);
    cs_n = 1'b1;
    repeat (8) @(posedge clk);
  endtask

  task automatic send(input string req, input int op, input int idx, input int data);
    cur_req = req;
    shift_out({8'h0, 4'(op), 4'(idx), 16'(data)}, 24);
    model(op, idx, data);
    cmp_en = 1;
    repeat (6) @(posedge clk);
  endtask

  task automatic send_bad(input string req, input int nbits);
    cur_req = req;
    shift_out(32'h0013_FFC0 | 32'h0030_0000, nbits);
    cmp_en = 1;
    repeat (6) @(posedge clk);
  endtask

  initial begin
    for (int i = 0; i < NCH; i++) begin exp_hold[i] = 0; exp_dac[i] = 0; exp_pd[i] = 0; end
    fork
      begin
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        cmp_en = 1;                          // R11 reset state
        repeat (4) @(posedge clk);
        rst_n = 1'b1;
        repeat (4) @(posedge clk);
        send("R4", 0, 0, 16'h8000);          // hold only, no output change
        send("R5", 1, 0, 16'h0000);          // copy hold to active
        send("R4", 0, 1, 16'h1240);
        send("R4", 0, 2, 16'hFFC0);
        send("R6", 2, 3, 16'h5540);          // load all incl. new code on ch3
        send("R2", 3, 1, 16'hA5FF);          // low 6 bits are don't-care
        send("R7", 3, 2, 16'h0C3F);
        send("R8", 4, 2, 16'h0000);
        send("R8", 4, 0, 16'hFFFF);
        send("R8", 5, 9, 16'h1234);          // chip powerdown ignores index
        send("R7", 3, 2, 16'h4000);          // wakes ch2 and chip, ch0 stays down
        send("R9", 7, 15, 16'hFFFF);
        send("R9", 6, 3, 16'hABCD);
        send("R9", 7, 0, 16'h0000);
        send("R10", 4, 5, 16'h0000);
        send("R10", 0, 9, 16'hFFC0);
        send("R10", 2, 15, 16'hFFC0);
        send("R10", 3, 4, 16'hFFC0);
        send("R10", 9, 1, 16'hFFC0);
        send("R10", 15, 0, 16'hFFC0);
        send("R3", 0, 3, 16'h7FC0);
        send_bad("R3", 23);                  // too short
        send_bad("R3", 25);                  // too long
        send("R1", 1, 3, 16'h0000);          // exact frame after discards
        send("R8", 4, 1, 16'h0000);
        send("R5", 1, 1, 16'h0000);
        send("R8", 5, 0, 16'h0000);
        send("R6", 2, 0, 16'h0040);
        send("R1", 3, 3, 16'h8040);
      end
      begin
        repeat (150000) @(posedge clk);
        miscompares++;
        $display("FAIL watchdog expired in %s", cur_req);
      end
    join_any
    disable fork;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule